// File: doc/BRIEF.md
# Nonvolatile Store/Recall Control Sequencer

This block is the clocked control unit for a static memory whose every word is shadowed by a nonvolatile copy. Four active-low control inputs arrive from the system pins: chip select, output enable, write strobe and nonvolatile select. Each is synchronized through two flops and decoded into one of six modes: standby, no-op, read, write, store and recall. While nonvolatile select is high the block simply gates read and write access to the working array and enables the data-bus drivers for reads.

With nonvolatile select low, the block can start a store (working array copied into the nonvolatile shadow) or a recall (shadow copied back into the working array). An operation starts only on the cycle the decoded mode *enters* the matching state. A held control level never starts a second operation. While an operation runs, the block reports busy for a parameterised number of cycles, blocks all array access and keeps the data bus released. It hands the actual data movement to a separate copy engine through start pulses and a done input. A recall always runs in two steps: an array-clear pulse, then a transfer pulse on the following cycle.

A single digital supply-good flag replaces analog voltage sensing. A store is refused while the flag is low, and a store in progress is aborted when the flag drops. The first time the flag is seen high after reset, an automatic recall of the restore length runs. Until that recall finishes, no array access is granted.

Top module: `nvram_seq_ctrl`

## Requirements
- R1: With ce_n=0, oe_n=0, we_n=1, nv_n=1 sampled, mem_rd and dq_oe are both 1. Decoded outputs follow the pins two clock edges after a change.
- R2: With ce_n=0, we_n=0, nv_n=1 (oe_n either value), mem_wr is 1 while mem_rd and dq_oe are 0. mem_rd and mem_wr are never 1 together.
- R3: With ce_n=1 (standby), mem_rd, mem_wr and dq_oe are 0 whatever the other pins are. After reset, busy and all pulse outputs are 0.
- R4: Entering store mode (ce_n=0, we_n=0, nv_n=0, oe_n=1) while idle with supply good gives a one-cycle store_go pulse. busy rises in that same cycle and stays high for STORE_CYC cycles.
- R5: Entering recall mode (ce_n=0, oe_n=0, nv_n=0, we_n=1) while idle gives recall_clr in the first busy cycle and recall_go in the next. busy stays high for RECALL_CYC cycles.
- R6: If the pins still hold the store or recall mode when the operation ends, no new operation starts. The pins must leave that mode and re-enter it to start another.
- R7: A store entry made while supply_ok (after synchronization) is low starts nothing.
- R8: If supply_ok falls during a store, a one-cycle store_abort pulse appears three cycles after the drop, and busy falls in that same cycle.
- R9: While busy, mem_rd, mem_wr and dq_oe are 0 and pin changes have no effect. In the first cycle after busy falls, the read or write mode present on the pins takes effect.
- R10: Before the first supply rise, access is blocked. The first rise of supply_ok runs a recall of RESTORE_CYC cycles (recall_clr, then recall_go). Later rises start nothing.
- R11: busy does not fall (except on abort) until copy_done has been sampled high after the start pulse. If copy_done comes late, busy falls in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| nv_n | input | 1 | Nonvolatile select, active low, asynchronous |
| supply_ok | input | 1 | Supply above threshold flag, asynchronous |
| copy_done | input | 1 | Copy engine reports the transfer finished |
| mem_rd | output | 1 | Read access granted to working array |
| mem_wr | output | 1 | Write access granted to working array |
| dq_oe | output | 1 | Drive data bus (0 = high impedance) |
| busy | output | 1 | Store or recall in progress |
| store_go | output | 1 | One-cycle pulse: start copy array to shadow |
| recall_clr | output | 1 | One-cycle pulse: clear working array |
| recall_go | output | 1 | One-cycle pulse: start copy shadow to array |
| store_abort | output | 1 | One-cycle pulse: running store abandoned |

## Verification
The assertions take for granted that copy_done is pulsed only while an operation waits for it. They also assume supply_ok does not toggle faster than the synchronizer can follow, so that the supply value three edges back is the one the store decision used. The stimulus changes every pin on the falling clock edge and holds each pin pattern for at least three cycles before the outcome is sampled. Unless a case deliberately withholds it, copy_done is returned exactly one cycle after each start pulse, so every busy window has a known, fixed length.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [2:0] {
    M_STBY, M_NOP, M_READ, M_WRITE, M_STORE, M_RECALL
  } mode_e;

  typedef enum logic [2:0] {
    S_OFF, S_IDLE, S_STORE, S_RCL_CLR, S_RCL_XFER
  } op_state_e;

  // Pin pattern to mode. Chip select high wins, then nonvolatile select
  // splits plain array access from shadow transfers.
  function automatic mode_e decode_mode(input logic ce_n, input logic oe_n,
                                        input logic we_n, input logic nv_n);
    mode_e m;
    if (ce_n)               m = M_STBY;
    else if (nv_n) begin
      if (!we_n)            m = M_WRITE;
      else if (!oe_n)       m = M_READ;
      else                  m = M_NOP;
    end else begin
      if (!we_n && oe_n)    m = M_STORE;
      else if (we_n && !oe_n) m = M_RECALL;
      else                  m = M_NOP;
    end
    return m;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nvseq_sync.sv
module nvseq_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;
endmodule

// File: rtl/nvseq_mode_track.sv
module nvseq_mode_track
  import nvseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_s,
  input  logic  oe_s,
  input  logic  we_s,
  input  logic  nv_s,
  output mode_e mode,
  output logic  enter_store,
  output logic  enter_recall
);
  mode_e prev_mode;

  assign mode = decode_mode(ce_s, oe_s, we_s, nv_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_mode <= M_STBY;
    else        prev_mode <= mode;
  end

  // Edge into the mode, never its level.
  assign enter_store  = (mode == M_STORE)  && (prev_mode != M_STORE);
  assign enter_recall = (mode == M_RECALL) && (prev_mode != M_RECALL);
endmodule

// File: rtl/nvseq_op_fsm.sv
module nvseq_op_fsm
  import nvseq_pkg::*;
#(
  parameter int STORE_CYC   = 40,
  parameter int RECALL_CYC  = 24,
  parameter int RESTORE_CYC = 60
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enter_store,
  input  logic      enter_recall,
  input  logic      supply_s,
  input  logic      copy_done,
  output op_state_e state,
  output logic      store_go,
  output logic      recall_clr,
  output logic      recall_go,
  output logic      store_abort,
  output logic      done_any
);
  localparam int MAXC = max3(STORE_CYC, RECALL_CYC, RESTORE_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          done_seen;

  // Count loaded at start: the first busy cycle is cycle zero.
  function automatic logic [CW-1:0] load_for(input int dur);
    return CW'(dur - 1);
  endfunction

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  assign done_any = done_seen | copy_done;

  logic finish;
  assign finish = (cnt == '0) && done_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_OFF;
      cnt         <= '0;
      done_seen   <= 1'b0;
      store_go    <= 1'b0;
      recall_clr  <= 1'b0;
      recall_go   <= 1'b0;
      store_abort <= 1'b0;
    end else begin
      store_go    <= 1'b0;
      recall_clr  <= 1'b0;
      recall_go   <= 1'b0;
      store_abort <= 1'b0;
      case (state)
        S_OFF: begin
          if (supply_s) begin
            state      <= S_RCL_CLR;
            cnt        <= load_for(RESTORE_CYC);
            done_seen  <= 1'b0;
            recall_clr <= 1'b1;
          end
        end
        S_IDLE: begin
          if (enter_store && supply_s) begin
            state     <= S_STORE;
            cnt       <= load_for(STORE_CYC);
            done_seen <= 1'b0;
            store_go  <= 1'b1;
          end else if (enter_recall) begin
            state      <= S_RCL_CLR;
            cnt        <= load_for(RECALL_CYC);
            done_seen  <= 1'b0;
            recall_clr <= 1'b1;
          end
        end
        S_STORE: begin
          if (!supply_s) begin
            state       <= S_IDLE;
            store_abort <= 1'b1;
          end else if (finish) begin
            state <= S_IDLE;
          end else begin
            cnt       <= step_down(cnt);
            done_seen <= done_any;
          end
        end
        S_RCL_CLR: begin
          state     <= S_RCL_XFER;
          cnt       <= step_down(cnt);
          recall_go <= 1'b1;
        end
        S_RCL_XFER: begin
          if (finish) begin
            state <= S_IDLE;
          end else begin
            cnt       <= step_down(cnt);
            done_seen <= done_any;
          end
        end
        default: state <= S_OFF;
      endcase
    end
  end
endmodule

// File: rtl/nvram_seq_ctrl.sv
module nvram_seq_ctrl
  import nvseq_pkg::*;
#(
  parameter int STORE_CYC   = 40,
  parameter int RECALL_CYC  = 24,
  parameter int RESTORE_CYC = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic nv_n,
  input  logic supply_ok,
  input  logic copy_done,
  output logic mem_rd,
  output logic mem_wr,
  output logic dq_oe,
  output logic busy,
  output logic store_go,
  output logic recall_clr,
  output logic recall_go,
  output logic store_abort
);
  logic [3:0] ctl_s;
  logic       supply_s;
  mode_e      mode;
  logic       enter_store;
  logic       enter_recall;
  op_state_e  state;
  logic       done_any;

  nvseq_sync #(.W(4), .RST_VAL(4'b1111)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({ce_n, oe_n, we_n, nv_n}), .q_sync(ctl_s)
  );

  nvseq_sync #(.W(1), .RST_VAL(1'b0)) u_sup_sync (
    .clk(clk), .rst_n(rst_n), .d_async(supply_ok), .q_sync(supply_s)
  );

  nvseq_mode_track u_mode (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ctl_s[3]), .oe_s(ctl_s[2]), .we_s(ctl_s[1]), .nv_s(ctl_s[0]),
    .mode(mode), .enter_store(enter_store), .enter_recall(enter_recall)
  );

  nvseq_op_fsm #(
    .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC), .RESTORE_CYC(RESTORE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .enter_store(enter_store), .enter_recall(enter_recall),
    .supply_s(supply_s), .copy_done(copy_done),
    .state(state), .store_go(store_go), .recall_clr(recall_clr),
    .recall_go(recall_go), .store_abort(store_abort), .done_any(done_any)
  );

  logic idle;
  assign idle   = (state == S_IDLE);
  assign busy   = (state == S_STORE) || (state == S_RCL_CLR) || (state == S_RCL_XFER);
  assign mem_rd = idle && (mode == M_READ);
  assign mem_wr = idle && (mode == M_WRITE);
  assign dq_oe  = mem_rd;
endmodule

// File: rtl/nvseq_chk.sv
module nvseq_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic mem_rd,
  input logic mem_wr,
  input logic dq_oe,
  input logic busy,
  input logic store_go,
  input logic recall_clr,
  input logic recall_go,
  input logic store_abort,
  input logic done_any
);
  a_r2_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r4_pulses_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_go, recall_clr, recall_go, store_abort}));

  a_r4_store_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |-> busy ##1 !store_go);

  a_r5_clear_then_copy: assert property (@(posedge clk) disable iff (!rst_n)
    recall_clr |=> (recall_go && busy));

  a_r7_store_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |-> $past(supply_ok, 3));

  a_r8_abort_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    store_abort |-> !busy);

  a_r9_no_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!mem_rd && !mem_wr && !dq_oe));

  a_r11_end_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !store_abort) |-> $past(done_any));
endmodule

bind nvram_seq_ctrl nvseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .dq_oe(dq_oe), .busy(busy),
  .store_go(store_go), .recall_clr(recall_clr), .recall_go(recall_go),
  .store_abort(store_abort), .done_any(done_any)
);

// File: tb/tb_nvram_seq_ctrl.sv
module tb_nvram_seq_ctrl;
  localparam int SC = 12;
  localparam int RC = 8;
  localparam int RS = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1;
  logic supply_ok = 1'b0, copy_done = 1'b0;
  logic mem_rd, mem_wr, dq_oe, busy, store_go, recall_clr, recall_go, store_abort;

  nvram_seq_ctrl #(.STORE_CYC(SC), .RECALL_CYC(RC), .RESTORE_CYC(RS)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n),
    .supply_ok(supply_ok), .copy_done(copy_done),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .dq_oe(dq_oe), .busy(busy),
    .store_go(store_go), .recall_clr(recall_clr), .recall_go(recall_go),
    .store_abort(store_abort)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nerr = 0;
  bit auto_done = 1'b1;
  bit finished = 1'b0;
  bit pbusy = 1'b0;

  // Event kinds: 0 busy rise, 1 clear, 2 store start, 3 copy start, 4 abort, 5 busy fall
  typedef struct { int kind; int at; string req; } ev_t;
  ev_t exp_q[$];

  task automatic expect_ev(input int k, input int at, input string req);
    ev_t e;
    e.kind = k; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic match(input int k);
    ev_t e;
    nchk++;
    if (exp_q.size() == 0) begin
      nerr++;
      $display("FAIL unexpected event: actual kind=%0d at %0d expected none", k, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.at != cyc) begin
        nerr++;
        $display("FAIL %s: actual kind=%0d at %0d expected kind=%0d at %0d",
                 e.req, k, cyc, e.kind, e.at);
      end
    end
  endtask

  // Monitor: compares observed events against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (busy && !pbusy) match(0);
      if (recall_clr)     match(1);
      if (store_go)       match(2);
      if (recall_go)      match(3);
      if (store_abort)    match(4);
      if (!busy && pbusy) match(5);
      pbusy = busy;
    end
  end

  // Copy engine model: done one cycle after each start pulse.
  always @(negedge clk) begin
    if (auto_done) copy_done = store_go || recall_go;
  end

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic ce, input logic oe, input logic we, input logic nv);
    ce_n = ce; oe_n = oe; we_n = we; nv_n = nv;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  int c0;
  initial begin
    wn(3);
    rst_n = 1'b1;
    wn(1);
    // R3 reset state
    chk(busy == 0 && store_go == 0 && recall_clr == 0 && recall_go == 0, "R3 reset pulses", busy, 0);
    chk(mem_rd == 0 && mem_wr == 0 && dq_oe == 0, "R3 reset access", mem_rd, 0);

    // R10 access blocked before first supply rise
    pins(0, 0, 1, 1);
    wn(4);
    chk(mem_rd == 0, "R10 blocked before power", mem_rd, 0);

    // R10 automatic recall at first rise
    c0 = cyc; supply_ok = 1'b1;
    expect_ev(0, c0 + 3, "R10 rise"); expect_ev(1, c0 + 3, "R10 clear");
    expect_ev(3, c0 + 4, "R10 copy"); expect_ev(5, c0 + 3 + RS, "R10 fall");
    wn(RS + 5);
    chk(mem_rd == 1, "R1 read grant", mem_rd, 1);
    chk(dq_oe == 1, "R1 bus drive", dq_oe, 1);

    // R2 write, latency two edges
    pins(0, 1, 0, 1);
    wn(1);
    chk(mem_wr == 0, "R1 latency", mem_wr, 0);
    wn(1);
    chk(mem_wr == 1 && mem_rd == 0, "R2 write grant", mem_wr, 1);
    chk(dq_oe == 0, "R2 bus released", dq_oe, 0);
    pins(0, 0, 0, 1);
    wn(3);
    chk(mem_wr == 1 && mem_rd == 0, "R2 write with oe low", mem_rd, 0);

    // R3 standby
    pins(1, 0, 0, 0);
    wn(3);
    chk(mem_rd == 0 && mem_wr == 0 && dq_oe == 0, "R3 standby", mem_wr, 0);

    // R4 store on entry, R9 ignore pins then take read at end
    pins(0, 1, 1, 0);
    wn(3);
    chk(mem_rd == 0 && mem_wr == 0 && busy == 0, "R3 nop mode", busy, 0);
    c0 = cyc; we_n = 1'b0;
    expect_ev(0, c0 + 3, "R4 rise"); expect_ev(2, c0 + 3, "R4 start");
    expect_ev(5, c0 + 3 + SC, "R4 fall");
    wn(5);
    pins(0, 0, 1, 1);
    wn(3);
    chk(mem_rd == 0 && dq_oe == 0, "R9 read ignored while busy", mem_rd, 0);
    wn(SC - 5);
    chk(busy == 0 && mem_rd == 1, "R9 read at end", mem_rd, 1);

    // R6 held store does not retrigger
    pins(0, 1, 1, 0);
    wn(3);
    c0 = cyc; we_n = 1'b0;
    expect_ev(0, c0 + 3, "R6 rise"); expect_ev(2, c0 + 3, "R6 start");
    expect_ev(5, c0 + 3 + SC, "R6 fall");
    wn(SC + 12);
    chk(busy == 0, "R6 no retrigger", busy, 0);
    we_n = 1'b1;
    wn(3);
    c0 = cyc; we_n = 1'b0;
    expect_ev(0, c0 + 3, "R6 rearm rise"); expect_ev(2, c0 + 3, "R6 rearm start");
    expect_ev(5, c0 + 3 + SC, "R6 rearm fall");
    wn(SC + 5);

    // R5 recall, R9 write ignored then applied
    pins(0, 1, 1, 0);
    wn(3);
    c0 = cyc; oe_n = 1'b0;
    expect_ev(0, c0 + 3, "R5 rise"); expect_ev(1, c0 + 3, "R5 clear");
    expect_ev(3, c0 + 4, "R5 copy"); expect_ev(5, c0 + 3 + RC, "R5 fall");
    wn(5);
    pins(0, 1, 0, 1);
    wn(2);
    chk(mem_wr == 0, "R9 write ignored while busy", mem_wr, 0);
    wn(RC - 4);
    chk(busy == 0 && mem_wr == 1, "R9 write at end", mem_wr, 1);

    // R11 late done
    pins(0, 1, 1, 0);
    wn(3);
    auto_done = 1'b0;
    c0 = cyc; oe_n = 1'b0;
    expect_ev(0, c0 + 3, "R11 rise"); expect_ev(1, c0 + 3, "R11 clear");
    expect_ev(3, c0 + 4, "R11 copy");
    wn(RC + 7);
    chk(busy == 1, "R11 waits for done", busy, 1);
    copy_done = 1'b1;
    expect_ev(5, cyc + 1, "R11 fall after done");
    wn(1);
    copy_done = 1'b0;
    auto_done = 1'b1;
    chk(busy == 0, "R11 released", busy, 0);

    // R7 store inhibited with supply low; R10 later rise does nothing
    pins(0, 1, 1, 0);
    supply_ok = 1'b0;
    wn(4);
    we_n = 1'b0;
    wn(SC);
    chk(busy == 0, "R7 store inhibited", busy, 0);
    supply_ok = 1'b1;
    wn(8);
    chk(busy == 0, "R10 second rise ignored", busy, 0);

    // R8 abort on supply drop
    we_n = 1'b1;
    wn(3);
    c0 = cyc; we_n = 1'b0;
    expect_ev(0, c0 + 3, "R8 rise"); expect_ev(2, c0 + 3, "R8 start");
    expect_ev(4, c0 + 9, "R8 abort"); expect_ev(5, c0 + 9, "R8 fall");
    wn(6);
    supply_ok = 1'b0;
    wn(5);
    chk(busy == 0, "R8 aborted", busy, 0);
    supply_ok = 1'b1;
    wn(6);

    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule